// File: doc/BRIEF.md
# Reloadable Down-Counting Interval Timer

A memory-mapped interval timer with a simple register bus. The bus has an address, a write strobe, write data and combinational read data. Software stores a start value and then sets the control bits. From then on the counter steps down by one on each pulse of the chosen tick input.

When the count steps from one to zero, the block raises a level interrupt. The interrupt stays high until software writes any value to the acknowledge register.

Once the counter sits at zero, the next tick acts according to the mode bit:
- In reload mode it takes the stored start value again, which gives a fixed period.
- In free-running mode it rolls over to the all-ones value.

Both tick pulses come from outside the block; any prescaling is done by the surrounding logic.

Top module: `interval_timer`

## Requirements
- R1: After reset the start value, the count, the control bits and the interrupt are all zero.
- R2: Offset 0x0 holds the start value and reads it back. A write there also places the written value into the count on the same clock edge, ahead of any tick.
- R3: Offset 0x4 reads the current count. Writes to 0x4 leave both the count and the start value unchanged.
- R4: Offset 0x8 is the control register: bit 0 = run, bit 1 = mode (1 reload, 0 free-running), bit 4 = tick select (0 slow input, 1 fast input). All other bits read as zero.
- R5: While run is set, each pulse on the selected tick input lowers a non-zero count by one. Pulses on the other tick input have no effect.
- R6: A tick that takes the count from 1 to 0 sets the interrupt output, which then stays high until acknowledged.
- R7: A write of any data to offset 0xC drops the interrupt on the next edge. If that write coincides with a tick that sets the interrupt, the interrupt stays high.
- R8: In reload mode, a tick at count zero loads the start value into the count.
- R9: In free-running mode, a tick at count zero sets the count to all ones.
- R10: While run is clear, ticks leave the count frozen at its current value.
- R11: Reads of offset 0xC and of any offset other than 0x0, 0x4 and 0x8 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W (4) | Register byte offset |
| we_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data for addr_i |
| tick_slow_i | input | 1 | Slow tick enable pulse |
| tick_fast_i | input | 1 | Fast tick enable pulse |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench runs an 8-bit build of the block and tries three kinds of counting.

The first is a sweep of start values 1 to 12 in reload mode. Each start value is counted down tick by tick against the arithmetic expected count. This separates a correct one-to-zero interrupt from an off-by-one interrupt, and a correct reload from a roll-over.

The second is a free-running run of 300 ticks from zero. It passes through the all-ones wrap more than once, which shows whether the wrap value and the modulo arithmetic are right.

The third is a set of interleaved pulses on the unselected tick input, together with ticks while run is clear. These separate tick selection and freezing from plain counting, and a same-cycle acknowledge and set confirms the priority between them.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int unsigned OFF_LOAD  = 'h0;
  localparam int unsigned OFF_COUNT = 'h4;
  localparam int unsigned OFF_CTRL  = 'h8;
  localparam int unsigned OFF_ACK   = 'hC;

  localparam int unsigned BIT_RUN  = 0;
  localparam int unsigned BIT_MODE = 1;
  localparam int unsigned BIT_SEL  = 4;

  typedef struct packed {
    logic sel;   // 1: fast tick
    logic mode;  // 1: reload, 0: free-running
    logic run;
  } ctrl_t;
endpackage

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] count_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] load_o,
  output ctrl_t             ctrl_o,
  output logic              load_we_o,
  output logic              ack_we_o
);
  logic [DATA_W-1:0] load_q;
  ctrl_t             ctrl_q;
  logic              ctrl_we;

  assign load_we_o = we_i && (addr_i == ADDR_W'(OFF_LOAD));
  assign ctrl_we   = we_i && (addr_i == ADDR_W'(OFF_CTRL));
  assign ack_we_o  = we_i && (addr_i == ADDR_W'(OFF_ACK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (load_we_o) load_q <= wdata_i;
      if (ctrl_we) begin
        ctrl_q.run  <= wdata_i[BIT_RUN];
        ctrl_q.mode <= wdata_i[BIT_MODE];
        ctrl_q.sel  <= wdata_i[BIT_SEL];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(OFF_LOAD):  rdata_o = load_q;
      ADDR_W'(OFF_COUNT): rdata_o = count_i;
      ADDR_W'(OFF_CTRL): begin
        rdata_o[BIT_RUN]  = ctrl_q.run;
        rdata_o[BIT_MODE] = ctrl_q.mode;
        rdata_o[BIT_SEL]  = ctrl_q.sel;
      end
      default: rdata_o = '0;
    endcase
  end

  assign load_o = load_q;
  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] load_i,
  input  logic              step_i,
  input  logic              reload_i,
  output logic [DATA_W-1:0] count_o,
  output logic              expire_o
);
  logic [DATA_W-1:0] cnt_q;
  logic              at_zero;

  assign at_zero  = (cnt_q == '0);
  assign expire_o = step_i && !load_we_i && (cnt_q == DATA_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_we_i) begin
      cnt_q <= wdata_i;
    end else if (step_i) begin
      if (!at_zero)      cnt_q <= cnt_q - 1'b1;
      else if (reload_i) cnt_q <= load_i;
      else               cnt_q <= '1;
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/timer_irq.sv
module timer_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  output logic irq_o
);
  logic irq_q;

  // set beats a coincident acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (set_i) irq_q <= 1'b1;
    else if (ack_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tick_slow_i,
  input  logic              tick_fast_i,
  output logic              irq_o
);
  logic [DATA_W-1:0] load_q;
  logic [DATA_W-1:0] cnt_q;
  ctrl_t             ctrl_q;
  logic              load_we, ack_we, step, expire;

  timer_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .we_i      (we_i),
    .wdata_i   (wdata_i),
    .count_i   (cnt_q),
    .rdata_o   (rdata_o),
    .load_o    (load_q),
    .ctrl_o    (ctrl_q),
    .load_we_o (load_we),
    .ack_we_o  (ack_we)
  );

  assign step = ctrl_q.run && (ctrl_q.sel ? tick_fast_i : tick_slow_i);

  timer_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_we_i (load_we),
    .wdata_i   (wdata_i),
    .load_i    (load_q),
    .step_i    (step),
    .reload_i  (ctrl_q.mode),
    .count_o   (cnt_q),
    .expire_o  (expire)
  );

  timer_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (expire),
    .ack_i  (ack_we),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/timer_chk.sv
module timer_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              tick_slow_i,
  input logic              tick_fast_i,
  input logic              irq_o,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] load,
  input logic              run,
  input logic              mode,
  input logic              sel
);
  logic ld_wr, ack_wr, tk, live;
  assign ld_wr  = we_i && (addr_i == ADDR_W'(timer_pkg::OFF_LOAD));
  assign ack_wr = we_i && (addr_i == ADDR_W'(timer_pkg::OFF_ACK));
  assign tk     = sel ? tick_fast_i : tick_slow_i;
  assign live   = run && tk && !ld_wr;

  a_r2_load_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_wr |=> cnt == $past(wdata_i));
  a_r5_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
  a_r6_irq_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && cnt == DATA_W'(1)) |=> irq_o);
  a_r6_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack_wr) |=> irq_o);
  a_r7_ack_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_wr && !(live && cnt == DATA_W'(1))) |=> !irq_o);
  a_r8_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && cnt == '0 && mode) |=> cnt == $past(load));
  a_r9_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && cnt == '0 && !mode) |=> &cnt);
  a_r10_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(run && tk) && !ld_wr) |=> $stable(cnt));
endmodule

bind interval_timer timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .we_i        (we_i),
  .wdata_i     (wdata_i),
  .tick_slow_i (tick_slow_i),
  .tick_fast_i (tick_fast_i),
  .irq_o       (irq_o),
  .cnt         (cnt_q),
  .load        (load_q),
  .run         (ctrl_q.run),
  .mode        (ctrl_q.mode),
  .sel         (ctrl_q.sel)
);

// File: tb/interval_timer_tb_top.sv
`timescale 1ns/1ps
module interval_timer_tb_top;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          tslow = 1'b0, tfast = 1'b0;
  logic          irq;
  int            checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  interval_timer #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .tick_slow_i(tslow), .tick_fast_i(tfast), .irq_o(irq)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); addr = AW'(a); wdata = DW'(d); we = 1'b1;
    @(negedge clk); we = 1'b0; addr = '0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk); addr = AW'(a); #1; d = int'(rdata);
  endtask

  task automatic tick(bit fast);
    @(negedge clk); if (fast) tfast = 1'b1; else tslow = 1'b1;
    @(negedge clk); tfast = 1'b0; tslow = 1'b0;
  endtask

  initial begin : watchdog
    #500000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int v;
    #12 rst_n = 1'b1;
    // R1 reset state
    rd(0, v); chk("R1 load", v, 0);
    rd(4, v); chk("R1 count", v, 0);
    rd(8, v); chk("R1 ctrl", v, 0);
    chk("R1 irq", int'(irq), 0);
    // R2 load write and copy
    wr(0, 5); rd(0, v); chk("R2 load rd", v, 5);
    rd(4, v); chk("R2 count copy", v, 5);
    // R3 count write ignored
    wr(4, 'h33); rd(4, v); chk("R3 count", v, 5);
    rd(0, v); chk("R3 load", v, 5);
    // R4 control fields
    wr(8, 'hFF); rd(8, v); chk("R4 ctrl", v, 'h13);
    // R11 unmapped reads
    rd('hC, v); chk("R11 ack rd", v, 0);
    rd(1, v); chk("R11 unmapped", v, 0);
    // reload sweep, slow tick
    for (int l = 1; l <= 12; l++) begin
      wr(8, 'h00); wr('hC, l * 7); chk("R7 ack", int'(irq), 0);
      wr(0, l); wr(8, 'h03);
      for (int j = 0; j < 3; j++) tick(1'b1);
      rd(4, v); chk("R5 other tick", v, l);
      for (int k = 1; k <= l; k++) begin
        tick(1'b0); rd(4, v); chk("R5 step", v, l - k);
        chk("R6 irq", int'(irq), (k == l) ? 1 : 0);
      end
      tick(1'b0); rd(4, v); chk("R8 reload", v, l);
      chk("R6 held", int'(irq), 1);
    end
    wr('hC, 0); chk("R7 ack zero data", int'(irq), 0);
    // free-running on fast tick
    wr(0, 2); wr(8, 'h11);
    tick(1'b1); tick(1'b1); rd(4, v); chk("R6 free zero", v, 0);
    chk("R6 free irq", int'(irq), 1);
    tick(1'b1); rd(4, v); chk("R9 wrap", v, 'hFF);
    tick(1'b0); rd(4, v); chk("R5 slow ignored", v, 'hFF);
    // R10 freeze
    wr(8, 'h10);
    for (int j = 0; j < 5; j++) tick(1'b1);
    rd(4, v); chk("R10 freeze", v, 'hFF);
    wr(8, 'h11); tick(1'b1); rd(4, v); chk("R10 resume", v, 'hFE);
    // R7 coincident set and ack
    wr(8, 'h03); wr('hC, 0); wr(0, 1);
    @(negedge clk); addr = AW'('hC); we = 1'b1; tslow = 1'b1;
    @(negedge clk); we = 1'b0; tslow = 1'b0; addr = '0;
    chk("R7 set wins", int'(irq), 1);
    // R9 long free-running sweep
    wr(8, 'h11); wr(0, 0);
    for (int k = 1; k <= 300; k++) begin
      tick(1'b1); rd(4, v); chk("R9 sweep", v, (256 - (k % 256)) % 256);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule